// File: doc/BRIEF.md
# LPC I/O Mailbox Target

This block is a target on the Low Pin Count bus. It watches the 4-bit multiplexed address/data lines, which are clocked by the PCI clock. It answers only host I/O read and I/O write cycles, and ignores every other cycle type. Decoded cycles land on three mailbox channels of the kind a keyboard controller uses. Each channel holds an input byte that the host writes, an output byte that firmware writes, and a status byte that carries the full flags and a command/data marker.

Channels 1 and 2 sit at fixed port pairs: 0x60/0x64 and 0x62/0x66. Channel 3 is placed by a base-address input. It also offers a small bank of extra bytes that both the host and firmware can read and write.

On the local side, firmware selects a channel and can read its input byte, which acknowledges it. Firmware can also load the output byte and watch the flags. A fast gate-A20 sequence on channel 1 is handled entirely in hardware.

Top module: `lpc_mailbox_target`

## Requirements
- R1: A cycle starts on a clock where `lframe_n` is low and `lad_in` is 0000. The next nibble is the cycle type: 0000 is an I/O read and 0010 is an I/O write. With any other type nibble the target never drives the bus and no register changes.
- R2: The 16-bit address follows the type nibble as four nibbles, most significant first. An address that matches no mapped port gets no bus drive and changes no register.
- R3: A write carries its data low nibble first. After the last host nibble the target leaves the bus undriven for two clocks. On the third clock it drives the SYNC value 0000, on the fourth it drives 1111, and after that it releases the bus.
- R4: On a read the target leaves the bus undriven for two clocks after the last address nibble. It then drives 0000, the data low nibble, the data high nibble and 1111, and then releases the bus.
- R5: A host write to a data port (0x60, 0x62, base+0) loads that channel's input byte, sets IBF and clears C/D. A host write to a command port (0x64, 0x66, base+1) loads the input byte, sets IBF and sets C/D. Firmware clears IBF by pulsing `fw_rd_idr` while `fw_ch` selects the channel; `fw_ch` values 0, 1 and 2 select channels 1, 2 and 3.
- R6: A firmware write pulse loads the selected channel's output byte and sets OBF. A host read of that channel's data port returns the output byte and clears OBF.
- R7: A host read of a command port returns the status byte, with OBF in bit 0, IBF in bit 1, C/D in bit 3 and all other bits 0. The read leaves every flag unchanged.
- R8: Channel 3 decodes addresses whose bits [15:5] equal `ch3_base[15:5]`. Offset 0 is its data port, offset 1 is its command port, and offset 0x10+k is extra byte k (k < 16). Host writes and reads reach the extra bytes. Firmware writes them with `fw_xwr`/`fw_xidx`/`fw_wdata` and reads them on `fw_xrdata`. Other offsets are unmapped.
- R9: A host write of 0xD1 to 0x64, followed by a host write to 0x60, sets `a20_gate` to bit 1 of the data byte. Neither of these two writes sets IBF. Any other write to 0x64 in between cancels the sequence, and that write is delivered normally.
- R10: Taking `lframe_n` low in the middle of a cycle abandons the cycle. A write abandoned before its high data nibble changes nothing, and the target still accepts the next cycle.
- R11: After reset all IBF, OBF and C/D flags are 0, the bus is not driven and `a20_gate` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Bus clock |
| lreset_n | input | 1 | Asynchronous active-low reset |
| lframe_n | input | 1 | Active-low frame, marks cycle start/abort |
| lad_in | input | 4 | Nibble received from the bus |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| ch3_base | input | 16 | Base I/O address of channel 3 (bits [15:5] used) |
| fw_ch | input | 2 | Firmware channel select (0..2) |
| fw_rd_idr | input | 1 | Firmware acknowledge of input byte (clears IBF) |
| fw_wr_odr | input | 1 | Firmware write strobe for output byte |
| fw_wdata | input | 8 | Firmware write data |
| fw_idr | output | 8 | Input byte of the selected channel |
| fw_ibf | output | 3 | IBF flags, bit i = channel i+1 |
| fw_obf | output | 3 | OBF flags, bit i = channel i+1 |
| fw_cd | output | 3 | C/D flags, bit i = channel i+1 |
| fw_xidx | input | 4 | Channel 3 extra byte index for firmware |
| fw_xwr | input | 1 | Firmware write strobe for extra byte |
| fw_xrdata | output | 8 | Extra byte at `fw_xidx` |
| a20_gate | output | 1 | Fast gate-A20 output |

## Verification
The bench records every driven nibble after each host cycle, so a SYNC one clock early or late, or data nibbles in swapped order, shows up as a mismatch. It sends a memory-type cycle, a miss on an unmapped port, and a write cut short by a new frame. A target that claimed any of these would drive the bus or raise IBF. The A20 sequence is run both completed and cancelled: a design that let the command through would raise IBF, and a design that kept its armed state too long would move the gate on an ordinary data byte. Status reads are issued back to back with reads of the data byte to show that status reads leave the flags alone, while data-port reads clear OBF.

// File: rtl/lpcmb_pkg.sv
package lpcmb_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_CTYP, S_ADDR, S_WDAT0, S_WDAT1,
      S_TAR, S_SYNC, S_RDAT0, S_RDAT1, S_TEND
   } link_state_e;

   typedef enum logic [1:0] {P_DATA, P_CMD, P_XBYTE} port_kind_e;

   typedef struct packed {
      logic       hit;
      logic [1:0] ch;
      port_kind_e kind;
      logic [3:0] xidx;
   } port_hit_t;

   localparam logic [3:0] NIB_START = 4'h0;
   localparam logic [3:0] NIB_READY = 4'h0;
   localparam logic [3:0] NIB_PARK  = 4'hF;

endpackage

// File: rtl/lpcmb_decode.sv
module lpcmb_decode
   import lpcmb_pkg::*;
#(
   parameter logic [15:0] CH1_DATA    = 16'h0060,
   parameter logic [15:0] CH1_CMD     = 16'h0064,
   parameter logic [15:0] CH2_DATA    = 16'h0062,
   parameter logic [15:0] CH2_CMD     = 16'h0066,
   parameter int          CH3_CMD_OFS = 1,
   parameter int          XBYTES      = 16
) (
   input  logic [15:0] addr,
   input  logic [15:0] ch3_base,
   output port_hit_t   dec
);
   logic [4:0] ofs;
   assign ofs = addr[4:0];

   always_comb begin
      dec = '{hit: 1'b0, ch: 2'd0, kind: P_DATA, xidx: 4'd0};
      if (addr == CH1_DATA) begin
         dec.hit = 1'b1; dec.ch = 2'd0; dec.kind = P_DATA;
      end else if (addr == CH1_CMD) begin
         dec.hit = 1'b1; dec.ch = 2'd0; dec.kind = P_CMD;
      end else if (addr == CH2_DATA) begin
         dec.hit = 1'b1; dec.ch = 2'd1; dec.kind = P_DATA;
      end else if (addr == CH2_CMD) begin
         dec.hit = 1'b1; dec.ch = 2'd1; dec.kind = P_CMD;
      end else if (addr[15:5] == ch3_base[15:5]) begin
         dec.ch = 2'd2;
         if (ofs == 5'd0) begin
            dec.hit = 1'b1; dec.kind = P_DATA;
         end else if (ofs == 5'(CH3_CMD_OFS)) begin
            dec.hit = 1'b1; dec.kind = P_CMD;
         end else if (ofs[4] && (int'(ofs[3:0]) < XBYTES)) begin
            dec.hit = 1'b1; dec.kind = P_XBYTE; dec.xidx = ofs[3:0];
         end
      end
   end
endmodule

// File: rtl/lpcmb_link.sv
module lpcmb_link
   import lpcmb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frame_n,
   input  logic [3:0]  lad_in,
   output logic [3:0]  lad_out,
   output logic        lad_oe,
   output logic [15:0] cur_addr,
   input  logic        hit,
   input  logic [7:0]  rd_byte,
   output logic        rd_take,
   output logic        wr_take,
   output logic [7:0]  wr_byte
);
   link_state_e state;
   logic [1:0]  cnt;
   logic        is_wr;
   logic [15:0] addr_sr;
   logic [3:0]  wlo;
   logic [7:0]  rbyte;
   logic        addr_last;

   assign addr_last = (state == S_ADDR) && (cnt == 2'd3);
   assign cur_addr  = addr_last ? {addr_sr[11:0], lad_in} : addr_sr;
   assign rd_take   = addr_last && !is_wr && hit && frame_n;
   assign wr_take   = (state == S_WDAT1) && frame_n;
   assign wr_byte   = {lad_in, wlo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cnt     <= 2'd0;
         is_wr   <= 1'b0;
         addr_sr <= '0;
         wlo     <= '0;
         rbyte   <= '0;
      end else if (!frame_n) begin
         state <= (lad_in == NIB_START) ? S_CTYP : S_IDLE;
         cnt   <= 2'd0;
      end else begin
         unique case (state)
            S_IDLE: ;
            S_CTYP: begin
               if (lad_in[3:2] == 2'b00 && !lad_in[0]) begin
                  is_wr <= lad_in[1];
                  state <= S_ADDR;
               end else begin
                  state <= S_IDLE;
               end
               cnt <= 2'd0;
            end
            S_ADDR: begin
               addr_sr <= {addr_sr[11:0], lad_in};
               cnt     <= cnt + 2'd1;
               if (cnt == 2'd3) begin
                  cnt <= 2'd0;
                  if (!hit)       state <= S_IDLE;
                  else if (is_wr) state <= S_WDAT0;
                  else begin
                     state <= S_TAR;
                     rbyte <= rd_byte;
                  end
               end
            end
            S_WDAT0: begin
               wlo   <= lad_in;
               state <= S_WDAT1;
            end
            S_WDAT1: begin
               state <= S_TAR;
               cnt   <= 2'd0;
            end
            S_TAR: begin
               if (cnt == 2'd1) state <= S_SYNC;
               cnt <= cnt + 2'd1;
            end
            S_SYNC: begin
               state <= is_wr ? S_TEND : S_RDAT0;
               cnt   <= 2'd0;
            end
            S_RDAT0: state <= S_RDAT1;
            S_RDAT1: begin
               state <= S_TEND;
               cnt   <= 2'd0;
            end
            S_TEND: begin
               if (cnt == 2'd1) state <= S_IDLE;
               cnt <= cnt + 2'd1;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      lad_oe  = 1'b0;
      lad_out = 4'h0;
      unique case (state)
         S_SYNC:  begin lad_oe = 1'b1; lad_out = NIB_READY;   end
         S_RDAT0: begin lad_oe = 1'b1; lad_out = rbyte[3:0]; end
         S_RDAT1: begin lad_oe = 1'b1; lad_out = rbyte[7:4]; end
         S_TEND:  if (cnt == 2'd0) begin lad_oe = 1'b1; lad_out = NIB_PARK; end
         default: ;
      endcase
   end

   // R3/R4: every driven burst opens with the ready SYNC nibble
   assert_sync_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lad_oe) |-> lad_out == NIB_READY);
   // R10: a frame low always silences the target on the next clock
   assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |=> !lad_oe);
endmodule

// File: rtl/lpcmb_chan.sv
module lpcmb_chan (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       h_wr,
   input  logic       h_cmd,
   input  logic [7:0] h_wdata,
   input  logic       h_rd,
   input  logic       fw_rd,
   input  logic       fw_wr,
   input  logic [7:0] fw_wdata,
   output logic [7:0] idr,
   output logic [7:0] odr,
   output logic       ibf,
   output logic       obf,
   output logic       cd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idr <= '0; odr <= '0; ibf <= 1'b0; obf <= 1'b0; cd <= 1'b0;
      end else begin
         if (h_wr) begin
            idr <= h_wdata;
            cd  <= h_cmd;
            ibf <= 1'b1;
         end else if (fw_rd) begin
            ibf <= 1'b0;
         end
         if (fw_wr) begin
            odr <= fw_wdata;
            obf <= 1'b1;
         end else if (h_rd) begin
            obf <= 1'b0;
         end
      end
   end

   assert_ibf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      h_wr |=> ibf);
   assert_ibf_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_rd && !h_wr) |=> !ibf);
   assert_obf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fw_wr |=> obf);
   assert_obf_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (h_rd && !fw_wr) |=> !obf);
endmodule

// File: rtl/lpc_mailbox_target.sv
module lpc_mailbox_target
   import lpcmb_pkg::*;
#(
   parameter logic [15:0] CH1_DATA    = 16'h0060,
   parameter logic [15:0] CH1_CMD     = 16'h0064,
   parameter logic [15:0] CH2_DATA    = 16'h0062,
   parameter logic [15:0] CH2_CMD     = 16'h0066,
   parameter int          CH3_CMD_OFS = 1,
   parameter int          XBYTES      = 16,
   parameter bit          A20_EN      = 1'b1,
   parameter logic [7:0]  A20_CMD     = 8'hD1,
   parameter bit          A20_RESET   = 1'b1
) (
   input  logic        lclk,
   input  logic        lreset_n,
   input  logic        lframe_n,
   input  logic [3:0]  lad_in,
   output logic [3:0]  lad_out,
   output logic        lad_oe,
   input  logic [15:0] ch3_base,
   input  logic [1:0]  fw_ch,
   input  logic        fw_rd_idr,
   input  logic        fw_wr_odr,
   input  logic [7:0]  fw_wdata,
   output logic [7:0]  fw_idr,
   output logic [2:0]  fw_ibf,
   output logic [2:0]  fw_obf,
   output logic [2:0]  fw_cd,
   input  logic [3:0]  fw_xidx,
   input  logic        fw_xwr,
   output logic [7:0]  fw_xrdata,
   output logic        a20_gate
);
   localparam int NCH    = 3;
   localparam int XIDX_W = (XBYTES > 1) ? $clog2(XBYTES) : 1;

   if (XBYTES < 2 || XBYTES > 16 || (XBYTES & (XBYTES - 1)) != 0) begin : g_bad_xbytes
      $error("XBYTES must be a power of two from 2 to 16");
   end
   if (CH3_CMD_OFS < 1 || CH3_CMD_OFS > 15) begin : g_bad_ofs
      $error("CH3_CMD_OFS must lie in 1..15");
   end

   logic [15:0] cur_addr;
   port_hit_t   dec;
   logic        rd_take, wr_take, swallow;
   logic [7:0]  wr_byte, rd_byte;
   logic [7:0]  idr_v [NCH];
   logic [7:0]  odr_v [NCH];
   logic [2:0]  ibf_v, obf_v, cd_v;
   logic [7:0]  xb [XBYTES];

   lpcmb_link u_link (
      .clk(lclk), .rst_n(lreset_n), .frame_n(lframe_n), .lad_in(lad_in),
      .lad_out(lad_out), .lad_oe(lad_oe), .cur_addr(cur_addr), .hit(dec.hit),
      .rd_byte(rd_byte), .rd_take(rd_take), .wr_take(wr_take), .wr_byte(wr_byte)
   );

   lpcmb_decode #(
      .CH1_DATA(CH1_DATA), .CH1_CMD(CH1_CMD), .CH2_DATA(CH2_DATA),
      .CH2_CMD(CH2_CMD), .CH3_CMD_OFS(CH3_CMD_OFS), .XBYTES(XBYTES)
   ) u_dec (.addr(cur_addr), .ch3_base(ch3_base), .dec(dec));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic h_wr_i, h_rd_i;
      assign h_wr_i = wr_take && dec.hit && dec.ch == 2'(i) && dec.kind != P_XBYTE
                      && !(i == 0 && swallow);
      assign h_rd_i = rd_take && dec.ch == 2'(i) && dec.kind == P_DATA;
      lpcmb_chan u_chan (
         .clk(lclk), .rst_n(lreset_n), .h_wr(h_wr_i), .h_cmd(dec.kind == P_CMD),
         .h_wdata(wr_byte), .h_rd(h_rd_i), .fw_rd(fw_rd_idr && fw_ch == 2'(i)),
         .fw_wr(fw_wr_odr && fw_ch == 2'(i)), .fw_wdata(fw_wdata),
         .idr(idr_v[i]), .odr(odr_v[i]), .ibf(ibf_v[i]), .obf(obf_v[i]), .cd(cd_v[i])
      );
   end

   assign fw_ibf = ibf_v;
   assign fw_obf = obf_v;
   assign fw_cd  = cd_v;

   always_comb begin
      unique case (fw_ch)
         2'd0:    fw_idr = idr_v[0];
         2'd1:    fw_idr = idr_v[1];
         2'd2:    fw_idr = idr_v[2];
         default: fw_idr = 8'h00;
      endcase
   end

   always_comb begin
      logic [7:0] odr_s, stat_s;
      unique case (dec.ch)
         2'd0:    begin odr_s = odr_v[0]; stat_s = {4'h0, cd_v[0], 1'b0, ibf_v[0], obf_v[0]}; end
         2'd1:    begin odr_s = odr_v[1]; stat_s = {4'h0, cd_v[1], 1'b0, ibf_v[1], obf_v[1]}; end
         default: begin odr_s = odr_v[2]; stat_s = {4'h0, cd_v[2], 1'b0, ibf_v[2], obf_v[2]}; end
      endcase
      unique case (dec.kind)
         P_DATA:  rd_byte = odr_s;
         P_CMD:   rd_byte = stat_s;
         default: rd_byte = xb[dec.xidx[XIDX_W-1:0]];
      endcase
   end

   always_ff @(posedge lclk or negedge lreset_n) begin
      if (!lreset_n) begin
         for (int k = 0; k < XBYTES; k++) xb[k] <= '0;
      end else if (wr_take && dec.hit && dec.kind == P_XBYTE) begin
         xb[dec.xidx[XIDX_W-1:0]] <= wr_byte;
      end else if (fw_xwr) begin
         xb[fw_xidx[XIDX_W-1:0]] <= fw_wdata;
      end
   end
   assign fw_xrdata = xb[fw_xidx[XIDX_W-1:0]];

   if (A20_EN) begin : g_a20
      logic armed, gate_q, c1_cmd, c1_dat;
      assign c1_cmd  = wr_take && dec.hit && dec.ch == 2'd0 && dec.kind == P_CMD;
      assign c1_dat  = wr_take && dec.hit && dec.ch == 2'd0 && dec.kind == P_DATA;
      assign swallow = (c1_cmd && wr_byte == A20_CMD) || (c1_dat && armed);
      always_ff @(posedge lclk or negedge lreset_n) begin
         if (!lreset_n) begin
            armed  <= 1'b0;
            gate_q <= A20_RESET;
         end else if (c1_cmd) begin
            armed <= (wr_byte == A20_CMD);
         end else if (c1_dat) begin
            armed <= 1'b0;
            if (armed) gate_q <= wr_byte[1];
         end
      end
      assign a20_gate = gate_q;

      // R9: the gate only moves right after a host write has completed
      assert_a20_cause_R9: assert property (@(posedge lclk) disable iff (!lreset_n)
         !$stable(a20_gate) |-> $past(wr_take));
   end else begin : g_no_a20
      assign swallow  = 1'b0;
      assign a20_gate = A20_RESET;
   end
endmodule

// File: tb/tb_lpc_mailbox_target.sv
`timescale 1ns/1ps
module tb_lpc_mailbox_target;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lframe_n = 1'b1;
   logic [3:0]  lad_in = 4'hF;
   logic [3:0]  lad_out;
   logic        lad_oe;
   logic [15:0] ch3_base = 16'h0A40;
   logic [1:0]  fw_ch = 2'd0;
   logic        fw_rd_idr = 1'b0, fw_wr_odr = 1'b0, fw_xwr = 1'b0;
   logic [7:0]  fw_wdata = 8'h00;
   logic [7:0]  fw_idr, fw_xrdata;
   logic [2:0]  fw_ibf, fw_obf, fw_cd;
   logic [3:0]  fw_xidx = 4'd0;
   logic        a20_gate;

   int total = 0, bad = 0;
   logic [34:0] cap_sig;
   logic [7:0]  cap_rd;

   always #4 clk = ~clk;

   lpc_mailbox_target dut (
      .lclk(clk), .lreset_n(rst_n), .lframe_n(lframe_n), .lad_in(lad_in),
      .lad_out(lad_out), .lad_oe(lad_oe), .ch3_base(ch3_base), .fw_ch(fw_ch),
      .fw_rd_idr(fw_rd_idr), .fw_wr_odr(fw_wr_odr), .fw_wdata(fw_wdata),
      .fw_idr(fw_idr), .fw_ibf(fw_ibf), .fw_obf(fw_obf), .fw_cd(fw_cd),
      .fw_xidx(fw_xidx), .fw_xwr(fw_xwr), .fw_xrdata(fw_xrdata), .a20_gate(a20_gate)
   );

   localparam logic [1:0] OP_HWR = 2'd0, OP_HRD = 2'd1, OP_FWO = 2'd2, OP_FWI = 2'd3;
   localparam int NVEC = 23;
   // {op, address (fw channel in [1:0] for firmware ops), data / expected}
   localparam logic [25:0] VEC [NVEC] = '{
      {OP_HRD, 16'h0064, 8'h00}, {OP_HWR, 16'h0060, 8'h5A}, {OP_HRD, 16'h0064, 8'h02},
      {OP_FWI, 16'h0000, 8'h5A}, {OP_HRD, 16'h0064, 8'h00}, {OP_HWR, 16'h0066, 8'h3C},
      {OP_HRD, 16'h0066, 8'h0A}, {OP_FWI, 16'h0001, 8'h3C}, {OP_FWO, 16'h0001, 8'hC3},
      {OP_HRD, 16'h0066, 8'h09}, {OP_HRD, 16'h0062, 8'hC3}, {OP_HRD, 16'h0066, 8'h08},
      {OP_HWR, 16'h0A40, 8'h77}, {OP_HRD, 16'h0A41, 8'h02}, {OP_FWI, 16'h0002, 8'h77},
      {OP_FWO, 16'h0002, 8'h99}, {OP_HRD, 16'h0A40, 8'h99}, {OP_HRD, 16'h0A41, 8'h00},
      {OP_HWR, 16'h0A53, 8'hE1}, {OP_HRD, 16'h0A53, 8'hE1}, {OP_HRD, 16'h0A54, 8'h00},
      {OP_HWR, 16'h0A5F, 8'h42}, {OP_HRD, 16'h0A5F, 8'h42}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [34:0] exp_sig(input bit wr, input logic [7:0] d);
      logic [34:0] s = '0;
      s[2*5 +: 5] = {1'b1, 4'h0};
      if (wr) s[3*5 +: 5] = {1'b1, 4'hF};
      else begin
         s[3*5 +: 5] = {1'b1, d[3:0]};
         s[4*5 +: 5] = {1'b1, d[7:4]};
         s[5*5 +: 5] = {1'b1, 4'hF};
      end
      return s;
   endfunction

   task automatic host_io(input bit wr, input logic [3:0] ct, input logic [15:0] a,
                          input logic [7:0] d);
      @(negedge clk); lframe_n = 1'b0; lad_in = 4'h0;
      @(negedge clk); lframe_n = 1'b1; lad_in = ct;
      for (int i = 3; i >= 0; i--) begin @(negedge clk); lad_in = a[i*4 +: 4]; end
      if (wr) begin
         @(negedge clk); lad_in = d[3:0];
         @(negedge clk); lad_in = d[7:4];
      end
      @(negedge clk); lad_in = 4'hF;
      cap_sig = '0;
      for (int j = 0; j < 7; j++) begin
         cap_sig[j*5 +: 5] = {lad_oe, lad_oe ? lad_out : 4'h0};
         if (j == 3) cap_rd[3:0] = lad_out;
         if (j == 4) cap_rd[7:4] = lad_out;
         @(negedge clk);
      end
   endtask

   task automatic fw_out(input logic [1:0] ch, input logic [7:0] d);
      @(negedge clk); fw_ch = ch; fw_wdata = d; fw_wr_odr = 1'b1;
      @(negedge clk); fw_wr_odr = 1'b0;
   endtask

   task automatic fw_in(input logic [1:0] ch, input logic [7:0] exp, input string req);
      @(negedge clk); fw_ch = ch; #1;
      chk(req, fw_idr, exp);
      fw_rd_idr = 1'b1;
      @(negedge clk); fw_rd_idr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 oe", lad_oe, 0); chk("R11 a20", a20_gate, 1);
      chk("R11 ibf", fw_ibf, 0); chk("R11 obf", fw_obf, 0); chk("R11 cd", fw_cd, 0);
      rst_n = 1'b1;

      // table walk: R5 R6 R7 R8 with R3/R4 timing on each host cycle
      for (int v = 0; v < NVEC; v++) begin
         logic [1:0] op; logic [15:0] a; logic [7:0] d;
         {op, a, d} = VEC[v];
         case (op)
            OP_HWR: begin
               host_io(1'b1, 4'h2, a, d);
               chk("R3 write response", cap_sig, exp_sig(1'b1, d));
            end
            OP_HRD: begin
               host_io(1'b0, 4'h0, a, d);
               chk("R4 read response", cap_sig, exp_sig(1'b0, d));
               chk("R6/R7/R8 read data", cap_rd, d);
            end
            OP_FWO: fw_out(a[1:0], d);
            default: fw_in(a[1:0], d, "R5 firmware input byte");
         endcase
      end
      chk("R5 flags after table", fw_ibf, 3'b000);
      chk("R6 obf after table", fw_obf, 3'b000);

      // R1: memory-read type nibble is ignored
      host_io(1'b1, 4'h4, 16'h0060, 8'hAA);
      chk("R1 no drive on non-I/O", cap_sig, 0);
      chk("R1 no ibf on non-I/O", fw_ibf, 0);
      // R2: unmapped ports
      host_io(1'b1, 4'h2, 16'h0061, 8'hAA);
      chk("R2 miss 0x61", cap_sig, 0);
      host_io(1'b0, 4'h0, 16'h0A42, 8'h00);
      chk("R2 miss ch3 offset 2", cap_sig, 0);
      chk("R2 no flags", fw_ibf, 0);

      // R10: abort a write after the low data nibble
      @(negedge clk); lframe_n = 1'b0; lad_in = 4'h0;
      @(negedge clk); lframe_n = 1'b1; lad_in = 4'h2;
      for (int i = 3; i >= 0; i--) begin @(negedge clk); lad_in = 4'(16'h0062 >> (i*4)); end
      @(negedge clk); lad_in = 4'h1;
      @(negedge clk); lframe_n = 1'b0; lad_in = 4'hF;
      @(negedge clk); lframe_n = 1'b1;
      begin
         logic seen = 1'b0;
         for (int j = 0; j < 6; j++) begin @(negedge clk); seen |= lad_oe; end
         chk("R10 no drive after abort", seen, 0);
      end
      chk("R10 aborted write ignored", fw_ibf[1], 0);
      host_io(1'b1, 4'h2, 16'h0062, 8'h11);
      chk("R10 recovery response", cap_sig, exp_sig(1'b1, 8'h11));
      fw_in(2'd1, 8'h11, "R10 recovery data");

      // R9: fast A20 sequence
      host_io(1'b1, 4'h2, 16'h0064, 8'hD1);
      host_io(1'b1, 4'h2, 16'h0060, 8'h00);
      chk("R9 gate cleared", a20_gate, 0);
      chk("R9 no ibf", fw_ibf[0], 0);
      host_io(1'b1, 4'h2, 16'h0064, 8'hD1);
      host_io(1'b1, 4'h2, 16'h0064, 8'hFF);
      host_io(1'b1, 4'h2, 16'h0060, 8'h02);
      chk("R9 cancelled gate", a20_gate, 0);
      chk("R9 cancelled ibf", fw_ibf[0], 1);
      chk("R5 data write clears cd", fw_cd[0], 0);
      fw_in(2'd0, 8'h02, "R9 cancelled byte delivered");
      host_io(1'b1, 4'h2, 16'h0064, 8'hD1);
      host_io(1'b1, 4'h2, 16'h0060, 8'h02);
      chk("R9 gate set", a20_gate, 1);

      // R8: firmware side of extra bytes
      @(negedge clk); fw_xidx = 4'd5; fw_wdata = 8'h6B; fw_xwr = 1'b1;
      @(negedge clk); fw_xwr = 1'b0;
      host_io(1'b0, 4'h0, 16'h0A55, 8'h00);
      chk("R8 host sees fw extra byte", cap_rd, 8'h6B);
      fw_xidx = 4'd3; #1;
      chk("R8 fw sees host extra byte", fw_xrdata, 8'hE1);

      // R7: back-to-back status reads leave flags alone
      fw_out(2'd0, 8'h5C);
      host_io(1'b0, 4'h0, 16'h0064, 8'h00);
      host_io(1'b0, 4'h0, 16'h0064, 8'h00);
      chk("R7 status stable", cap_rd, 8'h01);
      host_io(1'b0, 4'h0, 16'h0060, 8'h00);
      chk("R6 data after status reads", cap_rd, 8'h5C);
      chk("R6 obf cleared", fw_obf[0], 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule